// File: doc/BRIEF.md
# Inter/Intra-Frame Pixel Bus Decoder

This block sits on the receive side of a low-power off-chip pixel bus. The sender packs four 8-bit pixels into each 32-bit word and encodes every byte lane in three steps. It first takes the difference of the pixel from a predictor. It then maps that difference to a codeword whose count of ones grows with the size of the difference. Finally it sends the codeword as transitions against the last word on that lane. The decoder undoes the three steps one lane at a time and returns the original pixels.

Two prediction modes exist. In intraframe mode the predictor for a lane is the last pixel decoded on that lane. In interframe mode the predictor is the co-located pixel of an already decoded base frame, which the caller supplies on a reference input in the same cycle as the bus word. The base frame must therefore be fully decoded before any dependent frame that refers to it. The mode is chosen word by word. A search-area fetch is 128 words, which is 512 pixels. Output is registered one cycle after acceptance, under a valid/ready handshake.

Top module: `pixbus_decoder`

## Requirements
- R1: After reset, out_valid is 0 and out_word is 0.
- R2: For each lane, the codeword is the received byte XOR the byte received on that lane in the previous accepted word. The held received word resets to zero.
- R3: The codeword is turned into an index equal to its rank among all 256 byte values, sorted by number of ones and then by value. For example 0x00→0, 0x01→1, 0x80→8, 0x03→9, 0xFF→255.
- R4: With predictor p and t = min(p, 255−p), an index i ≤ 2t gives pixel p+(i+1)/2 for odd i and p−i/2 for even i.
- R5: An index i > 2t gives pixel p+(i−t) when p < 128, and p−(i−t) when p ≥ 128.
- R6: When inter is 1, the predictor of lane k is ref_word bits [8k+7:8k], sampled with the accepted word.
- R7: When inter is 0, the predictor of lane k is the pixel last decoded on lane k, in either mode. It is 0 after reset.
- R8: Lane k uses bits [8k+7:8k] of in_word, ref_word and out_word, and lanes do not affect one another.
- R9: in_ready is high when out_valid is 0 or out_ready is 1. An accepted word gives out_valid=1 with its pixels on the next cycle. While out_valid=1 and out_ready=0, out_word holds steady.
- R10: A cycle without acceptance changes no decoding state. If the output is also being taken in that cycle, out_valid drops to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Bus word present |
| in_ready | output | 1 | Decoder can accept a word |
| inter | input | 1 | 1 = predict from ref_word, 0 = from the last decoded pixel |
| in_word | input | 32 | Encoded bus word, four lanes |
| ref_word | input | 32 | Co-located base-frame pixels |
| out_valid | output | 1 | Decoded word present |
| out_ready | input | 1 | Consumer takes the decoded word |
| out_word | output | 32 | Four decoded pixels |

## Verification
The bench encodes pixel streams with its own model of the sender and requires exact reconstruction. The streams cover intraframe, interframe and mixed modes. The sharpest corners are pixels and predictors at 0 and 255, where the folded range t collapses to zero. A decoder that gets the far-index branch wrong there wraps around and returns pixels near the opposite extreme. Stalls and idle cycles with junk on in_word are aimed at state that updates without acceptance: a decoder with that fault loses its XOR reference and corrupts every word that follows. Streams that alternate modes catch a predictor register that fails to track pixels decoded in interframe mode.

// File: rtl/pixbus_decoder.sv
module pixbus_decoder #(
  parameter int LANES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic                 inter,
  input  logic [LANES*8-1:0]   in_word,
  input  logic [LANES*8-1:0]   ref_word,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [LANES*8-1:0]   out_word
);
  localparam int W = LANES * 8;

  function automatic int binom(input int n, input int k);
    int res;
    res = 1;
    for (int j = 0; j < k; j++) res = res * (n - j) / (j + 1);
    return res;
  endfunction

  function automatic logic [7:0] rank8(input logic [7:0] c);
    int ones, base, r, s;
    ones = 0;
    for (int b = 0; b < 8; b++) ones += int'(c[b]);
    base = 0;
    for (int w = 0; w < ones; w++) base += binom(8, w);
    r = ones;
    s = 0;
    for (int b = 7; b >= 0; b--)
      if (c[b]) begin
        s += binom(b, r);
        r--;
      end
    return 8'(base + s);
  endfunction

  function automatic logic [7:0] undecor(input logic [7:0] idx, input logic [7:0] pred);
    int i, p, t, x;
    i = int'(idx);
    p = int'(pred);
    t = (p < 128) ? p : 255 - p;
    if (i <= 2 * t) x = idx[0] ? p + (i + 1) / 2 : p - i / 2;
    else if (p < 128) x = p + (i - t);
    else x = p - (i - t);
    return 8'(x);
  endfunction

  logic [W-1:0] prev_rx, pred, pix;
  logic         take;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [7:0] cw, p;
    assign cw = in_word[l*8 +: 8] ^ prev_rx[l*8 +: 8];
    assign p  = inter ? ref_word[l*8 +: 8] : pred[l*8 +: 8];
    assign pix[l*8 +: 8] = undecor(rank8(cw), p);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_rx   <= '0;
      pred      <= '0;
      out_word  <= '0;
      out_valid <= 1'b0;
    end else begin
      if (take) begin
        prev_rx  <= in_word;
        pred     <= pix;
        out_word <= pix;
      end
      if (take) out_valid <= 1'b1;
      else if (out_ready) out_valid <= 1'b0;
    end
  end

  a_r9_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_word));
  a_r9_accept_valid: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);
  a_r2_prev_capture: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> prev_rx == $past(in_word));
  a_r10_idle_keep: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> $stable(prev_rx) && $stable(pred));
  a_r7_pred_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> pred == out_word);
endmodule

// File: tb/test_pixbus_decoder.sv
module test_pixbus_decoder;
  logic        clk = 0, rst_n = 0;
  logic        in_valid = 0, inter = 0, out_ready = 1;
  logic [31:0] in_word = '0, ref_word = '0;
  logic        in_ready, out_valid;
  logic [31:0] out_word;
  int checks = 0, failures = 0, cycles = 0;
  logic [7:0]  enc_map [256];
  logic [31:0] e_prev = '0, e_pred = '0;

  always #2.5 clk = ~clk;

  pixbus_decoder i_pixbus_decoder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .inter(inter), .in_word(in_word), .ref_word(ref_word),
    .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] fwd(input logic [7:0] x, input logic [7:0] p);
    int d, t, i;
    d = int'(x) - int'(p);
    t = (p < 128) ? int'(p) : 255 - int'(p);
    if (d >= -t && d <= t) i = (d > 0) ? 2 * d - 1 : -2 * d;
    else i = ((d < 0) ? -d : d) + t;
    return 8'(i);
  endfunction

  task automatic send(logic [31:0] pixw, logic [31:0] refw, logic md, string req);
    logic [31:0] tx;
    for (int l = 0; l < 4; l++) begin
      logic [7:0] p;
      p = md ? refw[l*8 +: 8] : e_pred[l*8 +: 8];
      tx[l*8 +: 8] = e_prev[l*8 +: 8] ^ enc_map[fwd(pixw[l*8 +: 8], p)];
    end
    e_prev = tx;
    e_pred = pixw;
    in_word = tx; ref_word = refw; inter = md; in_valid = 1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 0; in_word = $urandom; ref_word = $urandom;
    check({req, " valid"}, {31'b0, out_valid}, 32'd1);
    check(req, out_word, pixw);
  endtask

  task automatic t_reset;
    check("R1 out_valid", {31'b0, out_valid}, 32'd0);
    check("R1 out_word", out_word, 32'd0);
    check("R9 in_ready", {31'b0, in_ready}, 32'd1);
  endtask

  task automatic t_intra;
    for (int n = 0; n < 128; n++) send($urandom, $urandom, 0, "R2 R3 R4 R7 intra");
  endtask

  task automatic t_inter;
    for (int n = 0; n < 128; n++) begin
      logic [31:0] b, d;
      b = $urandom;
      for (int l = 0; l < 4; l++) d[l*8 +: 8] = b[l*8 +: 8] + 8'($urandom_range(0, 6)) - 8'd3;
      send(d, b, 1, "R6 R8 inter");
    end
  endtask

  task automatic t_extremes;
    send(32'hFF00FF00, 32'h0, 0, "R5 intra extremes");
    send(32'h00FF00FF, 32'h0, 0, "R5 intra swap");
    send(32'hFF00_80_7F, 32'h00FF_7F_80, 1, "R5 inter far");
    send(32'h0000FFFF, 32'hFFFF0000, 1, "R5 inter full span");
    send(32'h01FE0080, 32'h0, 0, "R4 near edge");
    send(32'h12345678, 32'h12345678, 1, "R4 inter exact");
  endtask

  task automatic t_mixed;
    for (int n = 0; n < 32; n++) send($urandom, $urandom, n[0], "R7 mixed modes");
  endtask

  task automatic t_stall;
    send(32'hA5A55A5A, 32'h0, 0, "R9 first");
    out_ready = 0;
    @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      in_valid = 1; in_word = $urandom;
      check("R9 stall in_ready", {31'b0, in_ready}, 32'd0);
      check("R9 stall hold", out_word, 32'hA5A55A5A);
      @(negedge clk);
    end
    in_valid = 0;
    out_ready = 1;
    send(32'h5A5AA5A5, 32'h0, 0, "R9 after stall");
  endtask

  task automatic t_idle;
    for (int k = 0; k < 4; k++) begin
      in_valid = 0; in_word = $urandom; inter = k[0];
      @(negedge clk);
      check("R10 idle valid", {31'b0, out_valid}, 32'd0);
    end
    send(32'h00FF7F80, 32'h0, 0, "R10 after idle");
    send(32'hC3C3C3C3, 32'h0, 0, "R10 after idle 2");
  endtask

  task automatic t_lanes;
    send(32'h00000000, 32'h0, 0, "R8 zero");
    send(32'h000000FF, 32'h0, 0, "R8 lane0 only");
    send(32'hFF000000, 32'h0, 0, "R8 lane3 only");
  endtask

  initial begin
    int idx;
    idx = 0;
    for (int w = 0; w <= 8; w++)
      for (int v = 0; v < 256; v++)
        if ($countones(8'(v)) == w) begin
          enc_map[idx] = 8'(v);
          idx++;
        end
    check("R3 map 0x80", {24'b0, enc_map[8]}, 32'h80);
    check("R3 map 0x03", {24'b0, enc_map[9]}, 32'h03);
    #1;
    t_reset;
    #10 rst_n = 1;
    @(negedge clk);
    t_reset;
    t_intra;
    t_inter;
    t_extremes;
    t_mixed;
    t_stall;
    t_idle;
    t_lanes;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=<20000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule